// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block drives the two active-low control strobes of a global-shutter image sensor. The clear strobe `pg_n` empties every pixel and begins a new integration. The transfer strobe `tx_n` moves the integrated charge into in-pixel storage. The exposure length is the number of clock cycles from the falling edge of `pg_n` to the falling edge of `tx_n`. When a frame has finished, a one-cycle `expo_done` pulse tells the downstream read-out logic that the pixel memory holds a new image.

Two trigger sources can be selected at run time. In free-run mode an internal frame timer fires once every programmed period. Each firing starts an exposure of the programmed length, clamped to the range 1 to period minus one. In external-trigger mode the external trigger passes through a two-flop synchroniser. The exposure then opens on the synchronised rising edge and closes on the synchronised falling edge. Both edges see the same two-cycle delay, so the exposure length equals the high time of the trigger.

A five-state machine controls the strobes and moves through its states in this order:

- **IDLE**: the strobes are high and the mode and settings are latched.
- **EXPOSE**: integration runs, and `pg_n` is low for the first pulse-width cycles.
- **XFER**: `tx_n` is low.
- **SETTLE**: both strobes are high.
- **REPORT**: `expo_done` is high.

The machine then returns to IDLE. Each transition is named as follows:

- **start**: IDLE to EXPOSE, on a timer tick or a synchronised rising edge.
- **close**: EXPOSE to XFER, when the exposure count is reached or a synchronised falling edge arrives.
- **release**: XFER to SETTLE, when the pulse width has elapsed.
- **report**: SETTLE to REPORT, unconditional.
- **rearm**: REPORT to IDLE, unconditional.

Top module: `shutter_seq`

## Requirements
- R1: Each exposure begins with a falling edge of `pg_n`. `pg_n` stays low for min(Weff, Eexp) cycles, where Weff = max(`pulse_w`, 1) and Eexp is the exposure length of that frame. While `pg_n` falls, `tx_n` is high.
- R2: `tx_n` falls when the exposure ends and stays low for exactly Weff cycles. The two strobes are never low in the same cycle.
- R3: With `mode_ext` = 0 (free-run), the time from the `pg_n` fall to the `tx_n` fall is Eeff cycles. Eeff is `expo_len` clamped to the range 1 to P−1, where P = max(`frame_period`, 2).
- R4: In free-run mode with Eeff + Weff + 3 ≤ P, consecutive `pg_n` falls are exactly P cycles apart.
- R5: A timer tick that arrives while an exposure is in progress is dropped. With P < Eeff + Weff + 3 ≤ 2P, consecutive `pg_n` falls are therefore 2P cycles apart.
- R6: With `mode_ext` = 1 (external trigger), the time from the `pg_n` fall to the `tx_n` fall equals the number of cycles for which `ext_trig` was held high.
- R7: In external-trigger mode the internal frame timer starts no exposure. With `ext_trig` held low, `pg_n` stays high.
- R8: `expo_done` is high for exactly one cycle, in the cycle after the one in which `tx_n` returns high.
- R9: A change of `mode_ext` takes effect only in IDLE. An exposure that is in progress finishes under the mode it started with.
- R10: While `rst_n` is low, `pg_n` and `tx_n` are high and `expo_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mode_ext | input | 1 | 0 selects free-run, 1 selects external trigger |
| frame_period | input | CNT_W | Free-run frame period in clocks |
| expo_len | input | CNT_W | Free-run exposure length in clocks |
| pulse_w | input | PW_W | Low time of each strobe, in clocks (0 is treated as 1) |
| ext_trig | input | 1 | Asynchronous external trigger; its high time sets the exposure |
| pg_n | output | 1 | Active-low clear/start-integration strobe |
| tx_n | output | 1 | Active-low charge-transfer strobe |
| expo_done | output | 1 | One-cycle pulse after the transfer has completed |

## Verification
The bench builds the block with CNT_W = 8 and PW_W = 2. With PW_W = 2 every pulse width from 0 to 3 can be swept, including the 0-to-1 substitution. Frame periods are swept from 5 to 9, and for each period every exposure value from 0 to period + 1 is tried. This covers both clamps, as well as the boundary between frames that fit inside one period and frames that lose the next tick and stretch to two periods. External trigger high times from 1 to 8 are swept against all pulse widths. A mode switch in the middle of an exposure then shows that the latched mode governs the frame already running.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPOSE,
        ST_XFER,
        ST_SETTLE,
        ST_REPORT
    } sh_state_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
    assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        if (period < CNT_W'(2)) last_idx = ONE;
        else                    last_idx = period - ONE;
    end

    assign tick = (cnt >= last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + ONE;
    end
endmodule

// File: rtl/expo_clamp.sv
module expo_clamp #(
    parameter int CNT_W = 16,
    parameter int PW_W  = 4
) (
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] len,
    input  logic [PW_W-1:0]  width,
    output logic [CNT_W-1:0] len_eff,
    output logic [PW_W-1:0]  width_eff
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_eff;

    always_comb begin
        per_eff = (period < CNT_W'(2)) ? CNT_W'(2) : period;
        if (len >= per_eff)   len_eff = per_eff - ONE;
        else if (len == '0)   len_eff = ONE;
        else                  len_eff = len;
        width_eff = (width == '0) ? PW_W'(1) : width;
    end
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PW_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ext,
    input  logic [CNT_W-1:0] frame_period,
    input  logic [CNT_W-1:0] expo_len,
    input  logic [PW_W-1:0]  pulse_w,
    input  logic             ext_trig,
    output logic             pg_n,
    output logic             tx_n,
    output logic             expo_done
);
    localparam logic [CNT_W-1:0] E_ONE = CNT_W'(1);
    localparam logic [PW_W-1:0]  P_ONE = PW_W'(1);
    localparam int               SYNC_STAGES = 2;

    sh_state_t        state, nxt;
    logic             mode_q;
    logic [CNT_W-1:0] eeff_q, ecnt, eeff;
    logic [PW_W-1:0]  weff_q, pcnt, weff;
    logic             tick, trg_rise, trg_fall;
    logic             start_req, close_req;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_trig),
        .rise  (trg_rise),
        .fall  (trg_fall)
    );

    frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (frame_period),
        .tick   (tick)
    );

    expo_clamp #(.CNT_W(CNT_W), .PW_W(PW_W)) u_clamp (
        .period    (frame_period),
        .len       (expo_len),
        .width     (pulse_w),
        .len_eff   (eeff),
        .width_eff (weff)
    );

    assign start_req = mode_ext ? trg_rise : tick;
    assign close_req = mode_q ? trg_fall : (ecnt == eeff_q - E_ONE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_req) nxt = ST_EXPOSE;
            ST_EXPOSE: if (close_req) nxt = ST_XFER;
            ST_XFER:   if (pcnt == weff_q - P_ONE) nxt = ST_SETTLE;
            ST_SETTLE: nxt = ST_REPORT;
            ST_REPORT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            eeff_q <= E_ONE;
            weff_q <= P_ONE;
        end else if (state == ST_IDLE) begin
            mode_q <= mode_ext;
            eeff_q <= eeff;
            weff_q <= weff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= '0;
            pcnt <= '0;
        end else if (state != nxt) begin
            ecnt <= '0;
            pcnt <= '0;
        end else begin
            if (state == ST_EXPOSE) ecnt <= ecnt + E_ONE;
            if (pcnt != '1)         pcnt <= pcnt + P_ONE;
        end
    end

    always_comb begin
        pg_n      = !((state == ST_EXPOSE) && (pcnt < weff_q));
        tx_n      = (state != ST_XFER);
        expo_done = (state == ST_REPORT);
    end
endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk
    import shutter_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pg_n,
    input logic      tx_n,
    input logic      expo_done,
    input sh_state_t state,
    input logic      mode_q
);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pg_n && !tx_n));

    // R1
    pg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_n) |-> tx_n);

    // R8
    done_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expo_done |-> ($past(tx_n) && !$past(tx_n, 2)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expo_done |=> !expo_done);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pg_n && tx_n && !expo_done));
endmodule

bind shutter_seq shutter_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pg_n      (pg_n),
    .tx_n      (tx_n),
    .expo_done (expo_done),
    .state     (state),
    .mode_q    (mode_q)
);

// File: tb/shutter_seq_test.sv
module shutter_seq_test;
    localparam int CW = 8;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ext = 1'b0;
    logic [CW-1:0] frame_period = 8'd8;
    logic [CW-1:0] expo_len = 8'd2;
    logic [PW-1:0] pulse_w = 2'd1;
    logic          ext_trig = 1'b0;
    logic          pg_n, tx_n, expo_done;

    int checks = 0;
    int errors = 0;

    int cyc = 0;
    int pg_fall = 0, prev_pg_fall = 0, pg_rise = 0;
    int tx_fall = 0, tx_rise = 0, done_cyc = 0;
    int dones = 0, pg_falls = 0;
    logic prev_pg = 1'b1, prev_tx = 1'b1, prev_done = 1'b0;

    always #2.5 clk = ~clk;

    shutter_seq #(.CNT_W(CW), .PW_W(PW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_ext     (mode_ext),
        .frame_period (frame_period),
        .expo_len     (expo_len),
        .pulse_w      (pulse_w),
        .ext_trig     (ext_trig),
        .pg_n         (pg_n),
        .tx_n         (tx_n),
        .expo_done    (expo_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_pg && !pg_n) begin prev_pg_fall = pg_fall; pg_fall = cyc; pg_falls++; end
            if (!prev_pg && pg_n) pg_rise = cyc;
            if (prev_tx && !tx_n) tx_fall = cyc;
            if (!prev_tx && tx_n) tx_rise = cyc;
            if (expo_done) begin
                done_cyc = cyc;
                dones++;
                // R8 pulse lasts a single cycle
                chk(!prev_done, "R8 done width", 2, 1);
            end
            prev_pg = pg_n;
            prev_tx = tx_n;
            prev_done = expo_done;
        end
    end

    task automatic wait_dones(input int n);
        int target;
        target = dones + n;
        while (dones < target) @(negedge clk);
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check_frame(input int ee, input int we, input string tag);
        chk(pg_rise - pg_fall == min2(we, ee), "R1 pg low time", pg_rise - pg_fall, min2(we, ee));
        chk(tx_fall - pg_fall == ee, tag, tx_fall - pg_fall, ee);
        chk(tx_rise - tx_fall == we, "R2 tx low time", tx_rise - tx_fall, we);
        chk(done_cyc - tx_rise == 1, "R8 done timing", done_cyc - tx_rise, 1);
    endtask

    task automatic run_free(input int p, input int e, input int w);
        int ee, we, gap;
        @(negedge clk);
        frame_period = CW'(p);
        expo_len = CW'(e);
        pulse_w = PW'(w);
        ee = (e >= p) ? p - 1 : ((e == 0) ? 1 : e);
        we = (w == 0) ? 1 : w;
        gap = (ee + we + 3 <= p) ? p : 2 * p;
        wait_dones(3);
        for (int k = 0; k < 2; k++) begin
            wait_dones(1);
            check_frame(ee, we, "R3 free exposure");
            if (gap == p) chk(pg_fall - prev_pg_fall == gap, "R4 frame spacing", pg_fall - prev_pg_fall, gap);
            else          chk(pg_fall - prev_pg_fall == gap, "R5 skipped tick", pg_fall - prev_pg_fall, gap);
        end
    endtask

    task automatic run_ext(input int h, input int w);
        int we;
        @(negedge clk);
        pulse_w = PW'(w);
        we = (w == 0) ? 1 : w;
        ext_trig = 1'b1;
        repeat (h) @(negedge clk);
        ext_trig = 1'b0;
        wait_dones(1);
        check_frame(h, we, "R6 ext exposure");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nfall;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(pg_n === 1'b1, "R10 pg_n in reset", int'(pg_n), 1);
        chk(tx_n === 1'b1, "R10 tx_n in reset", int'(tx_n), 1);
        chk(expo_done === 1'b0, "R10 done in reset", int'(expo_done), 0);
        rst_n = 1'b1;

        for (int p = 5; p <= 9; p++)
            for (int e = 0; e <= p + 1; e++)
                for (int w = 0; w < 4; w++)
                    run_free(p, e, w);

        // switch to external trigger; running frame completes first
        @(negedge clk);
        mode_ext = 1'b1;
        repeat (40) @(negedge clk);
        nfall = pg_falls;
        repeat (60) @(negedge clk);
        chk(pg_falls == nfall, "R7 no timer exposure", pg_falls - nfall, 0);
        chk(pg_n === 1'b1, "R7 pg_n idle", int'(pg_n), 1);

        for (int h = 1; h <= 8; h++)
            for (int w = 0; w < 4; w++)
                run_ext(h, w);

        // R9 mode change mid exposure
        @(negedge clk);
        expo_len = 8'd1;
        pulse_w = 2'd1;
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        mode_ext = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        wait_dones(1);
        chk(tx_fall - pg_fall == 6, "R9 latched mode", tx_fall - pg_fall, 6);
        wait_dones(1);
        chk(tx_fall - pg_fall == 1, "R9 new mode after idle", tx_fall - pg_fall, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule